// File: doc/BRIEF.md
# Biphase-Mark Consumer Digital Audio Transmitter

This block turns a stream of stereo PCM samples into one serial line in the consumer digital audio format. Every frame holds two subframes: the left sample goes in the first and the right sample in the second. Each subframe has 32 bit slots. A slot is sent as two half-slot line levels. The block runs from a clock at 128 times the frame rate, so it outputs one half-slot per clock cycle. A free-running time base tracks the half-slot, the subframe and the frame within a 192-frame block. From these it picks the sync pattern that opens each subframe.

The system above the block gives it a 192-bit channel-status vector, a sample-rate choice, a flag that restricts the rate to 48 kHz, and a copyright flag decoded from the incoming stream header. A configuration bit can force the status to "copy not allowed". The block sends the channel-status bit for frame n in both subframes of that frame. The sample rate and the copy permission are written into fixed positions of that status. A one-cycle strobe tells the source when to present the next stereo pair.

Top module: `bmc_audio_tx`

## Requirements
- R1: While reset is held, `line_out` and `sample_take` are 0. The first subframe after reset starts with the block-start pattern, with a preceding level of 0, and carries all-zero audio in both subframes of frame 0.
- R2: Slot layout inside a subframe: slots 0-3 are the sync pattern and slots 4-7 are auxiliary and always 0. Slots 8-27 carry the 20-bit sample, least significant bit in slot 8. Slot 28 (validity) and slot 29 (user) are 0, slot 30 is the channel-status bit and slot 31 is parity.
- R3: In slots 4 to 31 the line level changes at the start of every slot. It changes again at mid-slot exactly when the slot carries a 1.
- R4: The sync patterns in half-slot levels, first half first, are: X = 11100010, Y = 11100100, Z = 11101000. Each pattern is inverted when the line level just before it is 1. The second subframe always uses Y. The first subframe uses Z in frame 0 of a block and X in all other frames.
- R5: The frame counter runs 0 to 191 and then wraps, so Z appears once every 192 frames.
- R6: The parity slot makes the number of 1s in slots 4 to 31 of each subframe even.
- R7: `sample_take` is 1 during the last half-slot cycle of each frame (half-slot 127 of 0..127). The `left_pcm`/`right_pcm` values present in that cycle are sent in the next frame: left in the first subframe, right in the second.
- R8: The channel-status slot of both subframes of frame n carries `status_bits[n]`, except in the frames named in R9 and R10.
- R9: Frame 2 carries the copy permission. It is 0 when `force_no_copy` is 1. Otherwise it is the inverse of `hdr_copyright`.
- R10: Frames 24 to 27 carry the rate code (frame 24 first). `rate_sel` 0 (48 kHz) gives 0,1,0,0. `rate_sel` 1 (44.1 kHz) gives 0,0,0,0. `rate_sel` 2 (32 kHz) gives 1,1,0,0. `rate_sel` 3 is treated as 48 kHz. `lock_48k` = 1 forces the 48 kHz code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-slot clock, 128 times the frame rate |
| rst_n | input | 1 | Active-low synchronous reset |
| left_pcm | input | 20 | Left sample, taken when `sample_take` is 1 |
| right_pcm | input | 20 | Right sample, taken when `sample_take` is 1 |
| rate_sel | input | 2 | Sample rate: 0 = 48 kHz, 1 = 44.1 kHz, 2 = 32 kHz, 3 = 48 kHz |
| lock_48k | input | 1 | Forces the 48 kHz rate code |
| status_bits | input | 192 | Channel-status vector, bit n is sent in frame n |
| hdr_copyright | input | 1 | Copyright flag from the stream header |
| force_no_copy | input | 1 | Configuration bit: always mark copying as not allowed |
| sample_take | output | 1 | Strobe in the last half-slot of each frame |
| line_out | output | 1 | Biphase-mark coded line |

## Verification
The assertions assume the following:
- The configuration inputs and `status_bits` are stable across any frame in which they are read.
- Samples change only between `sample_take` strobes.
- The clock is continuous, so the relation between the half-slot counter and the line holds at every edge.

The bench keeps within these assumptions. It sets the configuration and the status vector before each reset and leaves them alone during a run. It drives new samples only on the falling edge where the strobe is 1. It then decodes the line on its own, slot by slot, against a model built from the requirements.

// File: rtl/bmc_pkg.sv
package bmc_pkg;
  localparam int SLOTS_PER_SUB    = 32;
  localparam int HALVES_PER_SUB   = 2 * SLOTS_PER_SUB;
  localparam int HALVES_PER_FRAME = 2 * HALVES_PER_SUB;
  localparam int PRE_SLOTS        = 4;
  localparam int AUX_SLOTS        = 4;
  localparam int AUDIO_W          = 20;
  localparam int AUDIO_LSB_SLOT   = PRE_SLOTS + AUX_SLOTS;
  localparam int VALID_SLOT       = AUDIO_LSB_SLOT + AUDIO_W;
  localparam int USER_SLOT        = VALID_SLOT + 1;
  localparam int CS_SLOT          = USER_SLOT + 1;
  localparam int PARITY_SLOT      = CS_SLOT + 1;
  localparam int COPY_FRAME       = 2;
  localparam int RATE_FRAME       = 24;
  localparam int RATE_BITS        = 4;

  typedef enum logic [1:0] {PRE_X = 2'd0, PRE_Y = 2'd1, PRE_Z = 2'd2} pre_e;
  typedef enum logic [1:0] {RATE_48K = 2'd0, RATE_44K1 = 2'd1,
                            RATE_32K = 2'd2, RATE_RSVD = 2'd3} rate_e;

  // half-slot levels, MSB is sent first, for a preceding level of 0
  function automatic logic [7:0] pre_pattern(pre_e p);
    case (p)
      PRE_Y:   return 8'b1110_0100;
      PRE_Z:   return 8'b1110_1000;
      default: return 8'b1110_0010;
    endcase
  endfunction

  // code[k] is sent in frame RATE_FRAME + k
  function automatic logic [RATE_BITS-1:0] rate_code(logic [1:0] sel, logic lock);
    rate_e r;
    r = lock ? RATE_48K : rate_e'(sel);
    case (r)
      RATE_44K1: return 4'b0000;
      RATE_32K:  return 4'b0011;
      default:   return 4'b0010;
    endcase
  endfunction

  function automatic logic status_override(int unsigned idx, logic raw, logic force_nc,
                                           logic hdr_cr, logic [RATE_BITS-1:0] code);
    if (idx == COPY_FRAME) return force_nc ? 1'b0 : !hdr_cr;
    if (idx >= RATE_FRAME && idx < RATE_FRAME + RATE_BITS) return code[idx - RATE_FRAME];
    return raw;
  endfunction

  // bit i of the result is the value of slot i; preamble and aux slots are zero
  function automatic logic [SLOTS_PER_SUB-1:0] build_word(logic [AUDIO_W-1:0] smp, logic cs);
    logic [SLOTS_PER_SUB-1:0] w;
    w = '0;
    w[VALID_SLOT-1:AUDIO_LSB_SLOT] = smp;
    w[CS_SLOT] = cs;
    w[PARITY_SLOT] = ^w[PARITY_SLOT-1:PRE_SLOTS];
    return w;
  endfunction
endpackage

// File: rtl/bmc_timebase.sv
module bmc_timebase
  import bmc_pkg::*;
#(
  parameter int FRAMES = 192,
  localparam int HC_W = $clog2(HALVES_PER_FRAME),
  localparam int FR_W = $clog2(FRAMES)
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [HC_W-1:0] half_cnt,
  output logic [FR_W-1:0] frame_idx,
  output logic            frame_end
);
  localparam logic [HC_W-1:0] HALF_LAST  = HC_W'(HALVES_PER_FRAME - 1);
  localparam logic [FR_W-1:0] FRAME_LAST = FR_W'(FRAMES - 1);

  logic block_end;

  assign frame_end = (half_cnt == HALF_LAST);
  assign block_end = frame_end && (frame_idx == FRAME_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      half_cnt  <= '0;
      frame_idx <= '0;
    end else begin
      half_cnt <= frame_end ? '0 : half_cnt + 1'b1;
      if (frame_end) frame_idx <= block_end ? '0 : frame_idx + 1'b1;
    end
  end

  a_r5_frame_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    frame_idx <= FRAME_LAST);
  a_r5_block_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    block_end |=> frame_idx == '0);
  a_r7_take_starts_frame: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (half_cnt == '0) && (frame_idx != $past(frame_idx)));
endmodule

// File: rtl/bmc_subframe_builder.sv
module bmc_subframe_builder
  import bmc_pkg::*;
#(
  parameter int FRAMES = 192,
  localparam int FR_W = $clog2(FRAMES)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     take,
  input  logic                     sub_sel,
  input  logic [FR_W-1:0]          frame_idx,
  input  logic [AUDIO_W-1:0]       left_pcm,
  input  logic [AUDIO_W-1:0]       right_pcm,
  input  logic [FRAMES-1:0]        status_bits,
  input  logic [1:0]               rate_sel,
  input  logic                     lock_48k,
  input  logic                     hdr_copyright,
  input  logic                     force_no_copy,
  output logic [SLOTS_PER_SUB-1:0] word,
  output pre_e                     pre_sel,
  output logic                     cs_bit
);
  logic [AUDIO_W-1:0]   left_q, right_q;
  logic [RATE_BITS-1:0] code;
  logic                 raw_cs;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_q  <= '0;
      right_q <= '0;
    end else if (take) begin
      left_q  <= left_pcm;
      right_q <= right_pcm;
    end
  end

  always_comb begin
    code    = rate_code(rate_sel, lock_48k);
    raw_cs  = status_bits[frame_idx];
    cs_bit  = status_override(32'(frame_idx), raw_cs, force_no_copy, hdr_copyright, code);
    word    = build_word(sub_sel ? right_q : left_q, cs_bit);
    if (sub_sel)                pre_sel = PRE_Y;
    else if (frame_idx == '0)   pre_sel = PRE_Z;
    else                        pre_sel = PRE_X;
  end

  a_r9_copy_forced: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_idx == FR_W'(COPY_FRAME) && force_no_copy) |-> !cs_bit);
  a_r9_copy_follows_header: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_idx == FR_W'(COPY_FRAME) && !force_no_copy) |-> (cs_bit != hdr_copyright));
  a_r10_lock_code: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_48k && frame_idx >= FR_W'(RATE_FRAME) && frame_idx < FR_W'(RATE_FRAME + RATE_BITS))
      |-> (cs_bit == (frame_idx == FR_W'(RATE_FRAME + 1))));
  a_r7_hold_between_takes: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(take) |-> $stable(left_q) && $stable(right_q));
endmodule

// File: rtl/bmc_line_encoder.sv
module bmc_line_encoder
  import bmc_pkg::*;
#(
  localparam int SLOT_W = $clog2(SLOTS_PER_SUB)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [SLOT_W-1:0]        slot,
  input  logic                     half,
  input  logic [SLOTS_PER_SUB-1:0] word,
  input  pre_e                     pre_sel,
  output logic                     line
);
  logic       lvl_q, inv_q, inv, nxt;
  logic       in_pre, slot_bit, pre_first, data_edge, mid_flip, sub_last;
  logic       ones_q;
  logic [2:0] pidx;
  logic [7:0] pat;

  always_comb begin
    in_pre    = (slot < SLOT_W'(PRE_SLOTS));
    pidx      = {slot[1:0], half};
    pat       = pre_pattern(pre_sel);
    pre_first = in_pre && (pidx == 3'd0);
    inv       = pre_first ? lvl_q : inv_q;
    slot_bit  = word[slot];
    if (in_pre)     nxt = pat[3'd7 - pidx] ^ inv;
    else if (!half) nxt = !lvl_q;
    else            nxt = slot_bit ? !lvl_q : lvl_q;
    data_edge = !in_pre && !half;
    mid_flip  = !in_pre && half && (nxt != lvl_q);
    sub_last  = (slot == SLOT_W'(SLOTS_PER_SUB - 1)) && half;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q  <= 1'b0;
      inv_q  <= 1'b0;
      ones_q <= 1'b0;
    end else begin
      lvl_q <= nxt;
      if (pre_first) inv_q <= lvl_q;
      if (pre_first)     ones_q <= 1'b0;
      else if (mid_flip) ones_q <= !ones_q;
    end
  end

  assign line = lvl_q;

  a_r3_slot_edge: assert property (@(posedge clk) disable iff (!rst_n)
    data_edge |=> line != $past(line));
  a_r3_mid_one: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_pre && half && slot_bit) |=> line != $past(line));
  a_r3_mid_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_pre && half && !slot_bit) |=> $stable(line));
  a_r4_preamble_lead: assert property (@(posedge clk) disable iff (!rst_n)
    pre_first |=> line != $past(line));
  a_r6_even_ones: assert property (@(posedge clk) disable iff (!rst_n)
    sub_last |-> !(ones_q ^ mid_flip));
endmodule

// File: rtl/bmc_audio_tx.sv
module bmc_audio_tx
  import bmc_pkg::*;
#(
  parameter int FRAMES_PER_BLOCK = 192
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [19:0]                 left_pcm,
  input  logic [19:0]                 right_pcm,
  input  logic [1:0]                  rate_sel,
  input  logic                        lock_48k,
  input  logic [FRAMES_PER_BLOCK-1:0] status_bits,
  input  logic                        hdr_copyright,
  input  logic                        force_no_copy,
  output logic                        sample_take,
  output logic                        line_out
);
  localparam int HC_W   = $clog2(HALVES_PER_FRAME);
  localparam int FR_W   = $clog2(FRAMES_PER_BLOCK);
  localparam int SLOT_W = $clog2(SLOTS_PER_SUB);

  logic [HC_W-1:0]          half_cnt;
  logic [FR_W-1:0]          frame_idx;
  logic                     frame_end;
  logic                     sub_sel, half;
  logic [SLOT_W-1:0]        slot;
  logic [SLOTS_PER_SUB-1:0] word;
  pre_e                     pre_sel;
  logic                     cs_bit;

  assign half    = half_cnt[0];
  assign slot    = half_cnt[HC_W-2:1];
  assign sub_sel = half_cnt[HC_W-1];
  assign sample_take = frame_end;

  bmc_timebase #(.FRAMES(FRAMES_PER_BLOCK)) u_timebase (
    .clk(clk), .rst_n(rst_n), .half_cnt(half_cnt),
    .frame_idx(frame_idx), .frame_end(frame_end)
  );

  bmc_subframe_builder #(.FRAMES(FRAMES_PER_BLOCK)) u_builder (
    .clk(clk), .rst_n(rst_n), .take(frame_end), .sub_sel(sub_sel),
    .frame_idx(frame_idx), .left_pcm(left_pcm), .right_pcm(right_pcm),
    .status_bits(status_bits), .rate_sel(rate_sel), .lock_48k(lock_48k),
    .hdr_copyright(hdr_copyright), .force_no_copy(force_no_copy),
    .word(word), .pre_sel(pre_sel), .cs_bit(cs_bit)
  );

  bmc_line_encoder u_encoder (
    .clk(clk), .rst_n(rst_n), .slot(slot), .half(half),
    .word(word), .pre_sel(pre_sel), .line(line_out)
  );

  a_r4_block_start_z: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_idx == '0 && !sub_sel) |-> pre_sel == PRE_Z);
  a_r8_same_cs_both_halves: assert property (@(posedge clk) disable iff (!rst_n)
    (half_cnt == HC_W'(HALVES_PER_SUB)) |-> cs_bit == $past(cs_bit));
endmodule

// File: tb/test_bmc_audio_tx.sv
`timescale 1ns/1ps
module test_bmc_audio_tx;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [19:0]  left_pcm = '0, right_pcm = '0;
  logic [1:0]   rate_sel = '0;
  logic         lock_48k = 1'b0, hdr_copyright = 1'b0, force_no_copy = 1'b0;
  logic [191:0] status_bits = '0;
  logic         sample_take, line_out;

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  logic dec_cs [0:191];
  int   z_count;

  always #2 clk = ~clk;

  bmc_audio_tx i_bmc_audio_tx (
    .clk(clk), .rst_n(rst_n), .left_pcm(left_pcm), .right_pcm(right_pcm),
    .rate_sel(rate_sel), .lock_48k(lock_48k), .status_bits(status_bits),
    .hdr_copyright(hdr_copyright), .force_no_copy(force_no_copy),
    .sample_take(sample_take), .line_out(line_out)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [19:0] gen(int f, int sub, int seed);
    if (seed == 1) return (f % 2) ? 20'hFFFFF : 20'h00001;
    return 20'((f * 40503 + sub * 977 + seed * 7919) ^ (f << 11));
  endfunction

  function automatic logic exp_cs(int f, logic [191:0] st, logic [1:0] rs, logic lk,
                                  logic frc, logic hdr);
    int eff;
    eff = lk ? 0 : (rs == 2'd3 ? 0 : int'(rs));
    case (f)
      2:  return frc ? 1'b0 : ~hdr;
      24: return eff == 2;
      25: return eff != 1;
      26, 27: return 1'b0;
      default: return st[f];
    endcase
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    left_pcm = '0; right_pcm = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_case(input string name, input int nframes, input int seed,
                          input logic [1:0] rs, input logic lk, input logic frc,
                          input logic hdr, input logic [191:0] st);
    logic exp_h [0:63];
    logic act_h [0:63];
    logic mlev, act_prev, last_line;
    int e_model = 0, e_pre = 0, e_aux = 0, e_bmc = 0, e_par = 0, e_cs = 0, e_aud = 0, e_take = 0, e_vu = 0;
    rate_sel = rs; lock_48k = lk; force_no_copy = frc; hdr_copyright = hdr; status_bits = st;
    z_count = 0;
    do_reset();
    mlev = 1'b0; act_prev = 1'b0; last_line = 1'b0;
    for (int idx = 0; idx < nframes * 128; idx++) begin
      int f, fb, sub, hp;
      @(negedge clk);
      f = idx / 128; fb = f % 192; sub = (idx / 64) % 2; hp = idx % 64;
      if (hp == 0) begin
        logic [31:0] w;
        logic [19:0] smp;
        logic [7:0]  pat;
        logic        lv;
        smp = (f == 0) ? 20'h0 : gen(f, sub, seed);
        w = '0;
        for (int i = 0; i < 20; i++) w[8 + i] = smp[i];
        w[30] = exp_cs(fb, st, rs, lk, frc, hdr);
        w[31] = ^w[30:4];
        pat = sub ? 8'b11100100 : (fb == 0 ? 8'b11101000 : 8'b11100010);
        for (int k = 0; k < 8; k++) exp_h[k] = pat[7 - k] ^ mlev;
        lv = exp_h[7];
        for (int s = 4; s < 32; s++) begin
          lv = ~lv; exp_h[2 * s] = lv;
          if (w[s]) lv = ~lv;
          exp_h[2 * s + 1] = lv;
        end
        mlev = lv;
        act_prev = last_line;
      end
      if (line_out !== exp_h[hp]) e_model++;
      if (sample_take !== ((idx % 128) == 126)) e_take++;
      act_h[hp] = line_out;
      last_line = line_out;
      if ((idx % 128) == 126) begin
        left_pcm  = gen(f + 1, 0, seed);
        right_pcm = gen(f + 1, 1, seed);
      end
      if (hp == 63) begin
        logic [31:0] b;
        logic [7:0]  got;
        logic [19:0] aud, smp;
        for (int k = 0; k < 8; k++) got[7 - k] = act_h[k] ^ act_prev;
        if (got == 8'b11101000) z_count++;
        if (got != (sub ? 8'b11100100 : (fb == 0 ? 8'b11101000 : 8'b11100010))) e_pre++;
        b = '0;
        for (int s = 4; s < 32; s++) begin
          if (act_h[2 * s] == (s == 4 ? act_h[7] : act_h[2 * s - 1])) e_bmc++;
          b[s] = act_h[2 * s] ^ act_h[2 * s + 1];
        end
        if (b[7:4] != 4'h0) e_aux++;
        if (b[28] || b[29]) e_vu++;
        if (^b[31:4]) e_par++;
        for (int i = 0; i < 20; i++) aud[i] = b[8 + i];
        smp = (f == 0) ? 20'h0 : gen(f, sub, seed);
        if (aud != smp) e_aud++;
        if (b[30] != exp_cs(fb, st, rs, lk, frc, hdr)) e_cs++;
        if (sub == 0) dec_cs[fb] = b[30];
      end
    end
    chk(e_model == 0, {"R3 line model ", name}, e_model, 0);
    chk(e_pre == 0,   {"R4 preambles ", name}, e_pre, 0);
    chk(e_aux == 0,   {"R2 aux zero ", name}, e_aux, 0);
    chk(e_vu == 0,    {"R2 validity/user zero ", name}, e_vu, 0);
    chk(e_bmc == 0,   {"R3 slot edges ", name}, e_bmc, 0);
    chk(e_par == 0,   {"R6 parity ", name}, e_par, 0);
    chk(e_aud == 0,   {"R7 audio ", name}, e_aud, 0);
    chk(e_cs == 0,    {"R8 status ", name}, e_cs, 0);
    chk(e_take == 0,  {"R7 take strobe ", name}, e_take, 0);
  endtask

  task automatic t_reset();
    logic [7:0] got;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(line_out === 1'b0, "R1 line in reset", line_out, 0);
    chk(sample_take === 1'b0, "R1 take in reset", sample_take, 0);
    rst_n = 1'b1;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      got[7 - k] = line_out;
    end
    chk(got == 8'b11101000, "R1 first pattern is Z", got, 8'hE8);
  endtask

  task automatic t_basic();
    run_case("basic", 4, 3, 2'd0, 1'b0, 1'b0, 1'b0, {6{32'hA5C3_0F96}});
    run_case("extremes", 3, 1, 2'd0, 1'b0, 1'b0, 1'b0, '0);
  endtask

  task automatic t_block();
    run_case("block", 194, 7, 2'd1, 1'b0, 1'b0, 1'b1, {6{32'h1234_9ABC}});
    chk(z_count == 2, "R5 Z once per 192 frames", z_count, 2);
  endtask

  task automatic t_copy();
    run_case("copy pass", 3, 5, 2'd0, 1'b0, 1'b0, 1'b0, '0);
    chk(dec_cs[2] == 1'b1, "R9 header clear -> copy allowed", dec_cs[2], 1);
    run_case("copy hdr", 3, 5, 2'd0, 1'b0, 1'b0, 1'b1, '1);
    chk(dec_cs[2] == 1'b0, "R9 header set -> no copy", dec_cs[2], 0);
    run_case("copy forced", 3, 5, 2'd0, 1'b0, 1'b1, 1'b0, '1);
    chk(dec_cs[2] == 1'b0, "R9 forced no copy", dec_cs[2], 0);
  endtask

  task automatic t_rate(input logic [1:0] rs, input logic lk, input logic [3:0] exp4, input string name);
    logic [3:0] got;
    run_case(name, 28, 9, rs, lk, 1'b0, 1'b0, '1);
    for (int k = 0; k < 4; k++) got[3 - k] = dec_cs[24 + k];
    chk(got == exp4, {"R10 rate code ", name}, got, exp4);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_copy();
    t_rate(2'd0, 1'b0, 4'b0100, "48k");
    t_rate(2'd1, 1'b0, 4'b0000, "44k1");
    t_rate(2'd2, 1'b0, 4'b1100, "32k");
    t_rate(2'd2, 1'b1, 4'b0100, "locked");
    t_block();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule